// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Slice with Carry Lookahead

This block is a purely combinational arithmetic logic slice for active-high operand words. A four-bit select code together with a mode input picks one of sixteen bitwise two-operand logic functions or one of sixteen arithmetic functions. Every arithmetic function is the sum of two per-bit addends formed from the operands, plus an optional carry. The carry input and the carry output are active low: a high carry input means that no carry enters.

Inside the slice, each bit forms a propagate term and a generate term. Carries are resolved by full lookahead by default, and a parameter can select a ripple chain instead. Wider words are built by connecting the carry output of one slice to the carry input of the next. The active-low group propagate and group generate outputs serve an external lookahead unit. An all-ones flag supports equality and magnitude comparison.

Top module: `alu4_slice`

## Requirements
- R1: With logic_mode_i high, each result bit depends only on a_i and b_i of that position. The mapping from sel_i is: 0011 gives zero, 1100 gives one, 1111 gives A, 1010 gives B, 0000 gives NOT A, 0101 gives NOT B, 0110 gives XOR, 1001 gives XNOR, 1011 gives AND, 0100 gives NAND, 1110 gives OR, 0001 gives NOR, 0111 gives A AND NOT B, 0010 gives NOT A AND B, 1101 gives A OR NOT B, 1000 gives NOT A OR B.
- R2: With logic_mode_i low and carry_n_i high, f_o is the low four bits of X + Y. X is chosen by sel_i[1:0]: 00 gives A, 01 gives A OR B, 10 gives A OR NOT B, 11 gives all ones. Y is chosen by sel_i[3:2]: 00 gives zero, 01 gives A AND NOT B, 10 gives A AND B, 11 gives A. As a result, 1001 is A plus B, 0110 is A minus B minus 1, 1100 is A shifted one place toward the MSB, 1111 is A minus 1, and 0011 is all ones.
- R3: Driving carry_n_i low in arithmetic mode adds one, so f_o becomes the low four bits of X + Y + 1.
- R4: carry_n_o is low exactly when X + Y + (carry_n_i ? 0 : 1) is 16 or more. This holds in both modes.
- R5: For sel_i = 0110 in arithmetic mode with carry_n_i low, f_o is A minus B. carry_n_o is low (no borrow) exactly when A >= B.
- R6: all_ones_o is high exactly when f_o is 1111. For sel_i = 0110 in arithmetic mode with carry_n_i high, this means A equals B.
- R7: gen_n_o is low exactly when X + Y is 16 or more, whatever the value of carry_n_i.
- R8: prop_n_o is low exactly when X OR Y is 1111, whatever the value of carry_n_i.
- R9: In logic mode, carry_n_i has no effect on f_o.
- R10: Four slices chained from carry_n_o to carry_n_i perform 16-bit A plus B (sel 1001) and A minus B (sel 0110 with the first carry_n_i low). The final carry_n_o reports carry or no-borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | High: logic functions; low: arithmetic |
| carry_n_i | input | 1 | Carry in, active low |
| f_o | output | WIDTH | Result |
| carry_n_o | output | 1 | Carry out of the top bit, active low |
| prop_n_o | output | 1 | Group propagate, active low |
| gen_n_o | output | 1 | Group generate, active low |
| all_ones_o | output | 1 | High when every result bit is one |

## Verification
The bench applies every combination of operands, select code, mode and carry. It therefore reaches the inverted carry sense: a design that reads the carry as active high would be off by one in every arithmetic result and would invert the borrow in subtraction. It also confirms that group generate and group propagate ignore the carry input, and that logic mode ignores the carry input; a leaky mode gate would flip result bits only when carry_n_i is low. Chained 16-bit add and subtract runs show whether the carries between slices line up. A bad lookahead term there corrupts the upper nibbles and the final borrow.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   localparam int SEL_W     = 4;
   localparam int MAX_WIDTH = 32;

   // first addend, picked by sel[1:0]
   typedef enum logic [1:0] {
      XT_A    = 2'b00,
      XT_OR   = 2'b01,
      XT_ORN  = 2'b10,
      XT_ONES = 2'b11
   } xterm_e;

   // second addend, picked by sel[3:2]
   typedef enum logic [1:0] {
      YT_ZERO = 2'b00,
      YT_ANDN = 2'b01,
      YT_AND  = 2'b10,
      YT_A    = 2'b11
   } yterm_e;

   // carry into position idx, two-level sum of products
   function automatic logic la_carry(input logic [MAX_WIDTH-1:0] gen,
                                     input logic [MAX_WIDTH-1:0] prop,
                                     input logic                 cin,
                                     input int                   idx);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < MAX_WIDTH; j++) begin
         if (j < idx) begin
            term = gen[j];
            for (int k = 0; k < MAX_WIDTH; k++) begin
               if (k > j && k < idx) term = term & prop[k];
            end
            acc = acc | term;
         end
      end
      term = cin;
      for (int k = 0; k < MAX_WIDTH; k++) begin
         if (k < idx) term = term & prop[k];
      end
      return acc | term;
   endfunction

endpackage

// File: rtl/alu_operand_terms.sv
module alu_operand_terms
   import alu_slice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [WIDTH-1:0] xt_o,
   output logic [WIDTH-1:0] yt_o
);

   xterm_e xsel;
   yterm_e ysel;

   assign xsel = xterm_e'(sel_i[1:0]);
   assign ysel = yterm_e'(sel_i[3:2]);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         unique case (xsel)
            XT_A:    xt_o[i] = a_i[i];
            XT_OR:   xt_o[i] = a_i[i] | b_i[i];
            XT_ORN:  xt_o[i] = a_i[i] | ~b_i[i];
            default: xt_o[i] = 1'b1;
         endcase
      end
      always_comb begin
         unique case (ysel)
            YT_ZERO: yt_o[i] = 1'b0;
            YT_ANDN: yt_o[i] = a_i[i] & ~b_i[i];
            YT_AND:  yt_o[i] = a_i[i] & b_i[i];
            default: yt_o[i] = a_i[i];
         endcase
      end
   end

   // the second addend is never set where the first is clear
   always_comb begin
      p_y_inside_x_r2: assert ((yt_o & ~xt_o) == '0)
         else $error("second addend bit outside first addend");
   end

endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net
   import alu_slice_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] prop_i,
   input  logic             cin_i,
   output logic [WIDTH:0]   carry_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);

   localparam int PAD = MAX_WIDTH - WIDTH;

   logic [MAX_WIDTH-1:0] gen_ext;
   logic [MAX_WIDTH-1:0] prop_ext;

   assign gen_ext  = {{PAD{1'b0}}, gen_i};
   assign prop_ext = {{PAD{1'b0}}, prop_i};

   if (LOOKAHEAD) begin : g_lookahead
      for (genvar i = 0; i <= WIDTH; i++) begin : g_pos
         assign carry_o[i] = la_carry(gen_ext, prop_ext, cin_i, i);
      end
      assign grp_gen_o = la_carry(gen_ext, prop_ext, 1'b0, WIDTH);
   end else begin : g_ripple
      logic [WIDTH:0] gchain;
      assign carry_o[0] = cin_i;
      assign gchain[0]  = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_pos
         assign carry_o[i+1] = gen_i[i] | (prop_i[i] & carry_o[i]);
         assign gchain[i+1]  = gen_i[i] | (prop_i[i] & gchain[i]);
      end
      assign grp_gen_o = gchain[WIDTH];
   end

   assign grp_prop_o = &prop_i;

   always_comb begin
      p_cin_entry_r3: assert (carry_o[0] == cin_i)
         else $error("carry at position zero differs from carry in");
      for (int i = 0; i < WIDTH; i++) begin
         p_chain_step_r4: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])))
            else $error("carry chain inconsistent at bit %0d", i);
      end
      p_grp_gen_forces_r7: assert (!grp_gen_o || carry_o[WIDTH])
         else $error("group generate without carry out");
      p_grp_prop_passes_r8: assert (!(grp_prop_o && cin_i) || carry_o[WIDTH])
         else $error("propagating group dropped the carry");
   end

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
   import alu_slice_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       sel_i,
   input  logic             logic_mode_i,
   input  logic             carry_n_i,
   output logic [WIDTH-1:0] f_o,
   output logic             carry_n_o,
   output logic             prop_n_o,
   output logic             gen_n_o,
   output logic             all_ones_o
);

   localparam logic [3:0] SEL_SUB = 4'b0110;

   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("alu4_slice: WIDTH must lie in 1..%0d", MAX_WIDTH);
   end
   if (SEL_W != 4) begin : g_bad_sel
      $error("alu4_slice: select width must be four");
   end

   logic [WIDTH-1:0] xt;
   logic [WIDTH-1:0] yt;
   logic [WIDTH-1:0] half_sum;
   logic [WIDTH:0]   carry;
   logic             grp_gen;
   logic             grp_prop;

   alu_operand_terms #(
      .WIDTH (WIDTH)
   ) u_terms (
      .a_i   (a_i),
      .b_i   (b_i),
      .sel_i (sel_i),
      .xt_o  (xt),
      .yt_o  (yt)
   );

   // generate = X AND Y (= Y), propagate = X OR Y (= X)
   alu_carry_net #(
      .WIDTH     (WIDTH),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_carry (
      .gen_i      (xt & yt),
      .prop_i     (xt | yt),
      .cin_i      (~carry_n_i),
      .carry_o    (carry),
      .grp_gen_o  (grp_gen),
      .grp_prop_o (grp_prop)
   );

   assign half_sum = xt ^ yt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_res
      assign f_o[i] = ~half_sum[i] ^ (~carry[i] & ~logic_mode_i);
   end

   assign carry_n_o  = ~carry[WIDTH];
   assign prop_n_o   = ~grp_prop;
   assign gen_n_o    = ~grp_gen;
   assign all_ones_o = &f_o;

   always_comb begin
      p_logic_no_carry_r9: assert (!logic_mode_i || f_o == ~(xt ^ yt))
         else $error("logic result depends on carries");
      p_sub_borrow_r5: assert (!(sel_i == SEL_SUB && !logic_mode_i && !carry_n_i)
                               || (carry_n_o == (a_i < b_i)))
         else $error("borrow flag disagrees with operand order");
      p_sub_equal_r6: assert (!(sel_i == SEL_SUB && !logic_mode_i && carry_n_i)
                              || (all_ones_o == (a_i == b_i)))
         else $error("equality flag disagrees with operands");
      p_gen_sets_carry_r7: assert (gen_n_o || !carry_n_o)
         else $error("group generate active but no carry out");
   end

endmodule

// File: tb/alu4_slice_tb.sv
module alu4_slice_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;

   // single slice under test
   logic [3:0] a, b, sel, f;
   logic       mode, cn, cn4, pn, gn, eq;

   alu4_slice u_dut (
      .a_i (a), .b_i (b), .sel_i (sel), .logic_mode_i (mode), .carry_n_i (cn),
      .f_o (f), .carry_n_o (cn4), .prop_n_o (pn), .gen_n_o (gn), .all_ones_o (eq)
   );

   // four slices chained by ripple carry
   logic [15:0] wa, wb, wf;
   logic [3:0]  wsel;
   logic        wcn;
   logic [4:0]  wc;
   logic [3:0]  wpn, wgn, weq;

   assign wc[0] = wcn;
   for (genvar k = 0; k < 4; k++) begin : g_chain
      alu4_slice u_nib (
         .a_i (wa[4*k +: 4]), .b_i (wb[4*k +: 4]), .sel_i (wsel), .logic_mode_i (1'b0),
         .carry_n_i (wc[k]), .f_o (wf[4*k +: 4]), .carry_n_o (wc[k+1]),
         .prop_n_o (wpn[k]), .gen_n_o (wgn[k]), .all_ones_o (weq[k])
      );
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: sel=%b mode=%b cn=%b a=%0d b=%0d actual %0d expected %0d",
                  req, sel, mode, cn, a, b, act, exp);
      end
   endtask

   function automatic int x_term(input int s, input int ua, input int ub);
      case (s & 3)
         0: return ua;
         1: return (ua | ub) & 15;
         2: return (ua | (~ub & 15)) & 15;
         default: return 15;
      endcase
   endfunction

   function automatic int y_term(input int s, input int ua, input int ub);
      case ((s >> 2) & 3)
         0: return 0;
         1: return ua & ~ub & 15;
         2: return ua & ub;
         default: return ua;
      endcase
   endfunction

   function automatic int logic_ref(input int s, input int ua, input int ub);
      int na, nb;
      na = ~ua & 15;
      nb = ~ub & 15;
      case (s)
         0:  return na;
         1:  return ~(ua | ub) & 15;
         2:  return na & ub;
         3:  return 0;
         4:  return ~(ua & ub) & 15;
         5:  return nb;
         6:  return ua ^ ub;
         7:  return ua & nb;
         8:  return na | ub;
         9:  return ~(ua ^ ub) & 15;
         10: return ub;
         11: return ua & ub;
         12: return 15;
         13: return ua | nb;
         14: return ua | ub;
         default: return ua;
      endcase
   endfunction

   initial begin
      // exhaustive single-slice sweep
      for (int s = 0; s < 16; s++) begin
         for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 2; c++) begin
               for (int ia = 0; ia < 16; ia++) begin
                  for (int ib = 0; ib < 16; ib++) begin
                     int xv, yv, sum, fexp;
                     @(posedge clk);
                     #1;
                     sel = 4'(s); mode = m[0]; cn = c[0]; a = 4'(ia); b = 4'(ib);
                     #3;
                     n_vec = n_vec + 1;
                     xv  = x_term(s, ia, ib);
                     yv  = y_term(s, ia, ib);
                     sum = xv + yv + (c == 0 ? 1 : 0);
                     if (m == 1) begin
                        fexp = logic_ref(s, ia, ib);
                        chk("R1/R9 logic result", int'(f), fexp);
                     end else begin
                        fexp = sum & 15;
                        chk(c == 0 ? "R3 arith result with carry" : "R2 arith result",
                            int'(f), fexp);
                     end
                     chk("R4 carry out", int'(cn4), (sum >= 16) ? 0 : 1);
                     chk("R7 group generate", int'(gn), (xv + yv >= 16) ? 0 : 1);
                     chk("R8 group propagate", int'(pn), ((xv | yv) == 15) ? 0 : 1);
                     chk("R6 all ones flag", int'(eq), (fexp == 15) ? 1 : 0);
                     if (s == 6 && m == 0 && c == 0) begin
                        chk("R5 subtract result", int'(f), (ia - ib) & 15);
                        chk("R5 no-borrow", int'(cn4), (ia >= ib) ? 0 : 1);
                     end
                     if (s == 6 && m == 0 && c == 1)
                        chk("R6 equality", int'(eq), (ia == ib) ? 1 : 0);
                  end
               end
            end
         end
      end

      // cascaded 16-bit add and subtract
      begin
         logic [15:0] lfsr;
         lfsr = 16'hACE1;
         for (int t = 0; t < 1500; t++) begin
            int ua, ub, exp_v, exp_c;
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wa = lfsr;
            wb = (t % 7 == 0) ? lfsr : {lfsr[7:0], lfsr[15:8]} ^ 16'(t);
            if (t % 3 == 0) begin
               wsel = 4'b0110; wcn = 1'b0;
            end else begin
               wsel = 4'b1001; wcn = (t % 2 == 0);
            end
            #3;
            n_vec = n_vec + 1;
            ua = int'(wa);
            ub = int'(wb);
            if (wsel == 4'b0110) begin
               exp_v = (ua - ub) & 16'hFFFF;
               exp_c = (ua >= ub) ? 0 : 1;
            end else begin
               exp_v = (ua + ub + (wcn ? 0 : 1)) & 16'hFFFF;
               exp_c = (ua + ub + (wcn ? 0 : 1) >= 65536) ? 0 : 1;
            end
            if (int'(wf) != exp_v) begin
               n_bad = n_bad + 1;
               $display("FAIL R10 chained result: a=%0d b=%0d sel=%b actual %0d expected %0d",
                        ua, ub, wsel, wf, exp_v);
            end
            if (int'(wc[4]) != exp_c) begin
               n_bad = n_bad + 1;
               $display("FAIL R10 chained carry: a=%0d b=%0d sel=%b actual %0d expected %0d",
                        ua, ub, wsel, wc[4], exp_c);
            end
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule